// File: doc/BRIEF.md
# SPI Word Slave with Request-Driven Transmit Loading

This block is an SPI slave for any of the four clock-polarity and clock-phase combinations. Both are fixed by parameters. It captures the MOSI stream into a parallel word. At the same time it shifts a parallel word out on MISO, most significant bit first. Each register runs on the system clock. SCK, slave-select and MOSI are oversampled through synchroniser chains, and each SCK transition becomes a one-cycle enable. SCK itself never clocks anything.

Outgoing words come from a request/write handshake. When a frame opens, the slave raises `tx_req_o`. Near the end of every word it raises the request again. The user answers by presenting a word on `tx_data_i` and pulsing `tx_wr_i`. A word that is not written in time goes out as all zeros. Tying `tx_wr_i` high reloads the parallel input at every opportunity. Each completed received word appears on `rx_data_o` with a one-cycle `rx_valid_o` strobe. Words can follow each other without gaps for as long as slave-select stays low. Releasing slave-select at any time abandons the frame.

Top module: `spi_word_slave`

## Requirements
- R1: With parameter CPOL the SCK idle level is CPOL, and the leading edge is the transition away from it. With CPHA=0, MOSI is sampled on leading edges and MISO changes on trailing edges. With CPHA=1, MISO changes on leading edges and MOSI is sampled on trailing edges. Both directions are transferred most significant bit first.
- R2: Every register is clocked by `clk`. SCK, slave-select and MOSI each pass through a two-stage synchroniser. Transfers are correct with SCK high and low phases of at least four `clk` periods each.
- R3: When slave-select falls, `tx_req_o` rises within three `clk` cycles and the transmit word is preset to zero. Until the first SCK edge of the frame, a `tx_wr_i` pulse puts `tx_data_i` directly on MISO as the first word. The first SCK edge closes this window.
- R4: In every word, `tx_req_o` rises again after the sample edge of the second-to-last bit. It stays high until the next word is loaded. With CPHA=0 that load happens at the shift edge that follows the last sample. With CPHA=1 it happens at the last sample edge itself.
- R5: While `tx_req_o` is high, a `tx_wr_i` pulse stores `tx_data_i` as the next word to send.
- R6: If no write has been accepted when the next word is loaded, that word is sent as all zeros on MISO.
- R7: With `tx_wr_i` held high, every word of the frame is loaded from `tx_data_i`.
- R8: After the last bit of each word is sampled, `rx_data_o` holds the received word (the first bit in bit W-1), and `rx_valid_o` is high for exactly one cycle.
- R9: Raising slave-select ends the frame. Within three cycles `miso_oe_o` and `tx_req_o` are low and the bit count is cleared, and no `rx_valid_o` follows for the partial word. The next frame starts again at bit W-1.
- R10: After reset, `miso_oe_o`, `miso_o`, `tx_req_o`, `rx_valid_o` and `rx_data_o` are all zero.
- R11: `miso_o` is zero whenever `miso_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all registers use it |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | SPI clock from the master, asynchronous |
| ss_n_i | input | 1 | Slave select, active low, asynchronous |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master, zero when not driving |
| miso_oe_o | output | 1 | High while MISO should be driven onto the bus |
| tx_data_i | input | WORD_W | Word offered for transmission |
| tx_wr_i | input | 1 | Write strobe for `tx_data_i` |
| tx_req_o | output | 1 | Request for the next outgoing word |
| rx_data_o | output | WORD_W | Last complete word received from MOSI |
| rx_valid_o | output | 1 | One-cycle strobe marking a new `rx_data_o` |

## Verification
The bench targets the word boundaries of back-to-back frames in all four modes. If the next-word load used the wrong edge, the first bit of every later word would be lost or repeated, and the master would read shifted data. Missed writes are placed in the first, a middle and the last word of a frame. A design that reused a stale word, or let an old write leak through, would send non-zero data where zeros are expected. A frame cut off after three bits, followed by a full frame, catches a bit counter that survives the abort and would misalign the next received word. Holding the write strobe high checks that the first-word window and each continuation window both pick up the parallel input.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  // One-cycle events derived from the synchronised serial inputs.
  typedef struct packed {
    logic active;  // slave-select asserted (synchronised)
    logic start;   // first cycle of a frame
    logic sample;  // SCK edge on which MOSI is captured
    logic shift;   // SCK edge on which MISO advances
  } spi_evt_t;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  // One flop chain per asynchronous input bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[i]}};
      else     chain <= {chain[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_slv_events.sv
module spi_slv_events
  import spi_slv_pkg::*;
#(
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     sck_s,
  input  logic     ss_n_s,
  output spi_evt_t evt_o
);

  logic sck_d, act_d;
  logic act, start, edge_any, lead, trail;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= CPOL;
      act_d <= 1'b0;
    end else begin
      sck_d <= sck_s;
      act_d <= act;
    end
  end

  assign act      = ~ss_n_s;
  assign start    = act & ~act_d;
  assign edge_any = act & ~start & (sck_s != sck_d);
  assign lead     = edge_any & (sck_s != CPOL);
  assign trail    = edge_any & (sck_s == CPOL);

  always_comb begin
    evt_o.active = act;
    evt_o.start  = start;
    if (CPHA) begin
      evt_o.sample = trail;
      evt_o.shift  = lead;
    end else begin
      evt_o.sample = lead;
      evt_o.shift  = trail;
    end
  end

endmodule

// File: rtl/spi_slv_rx.sv
module spi_slv_rx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              start,
  input  logic              sample,
  input  logic              mosi_s,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              req_open_o,
  output logic              word_done_o
);

  localparam int CW = (WORD_W > 2) ? $clog2(WORD_W) : 1;

  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] rx_sh;
  logic [WORD_W-1:0] rx_next;

  assign rx_next     = {rx_sh[WORD_W-2:0], mosi_s};
  assign word_done_o = sample & (cnt == CW'(WORD_W - 1));
  assign req_open_o  = sample & (cnt == CW'(WORD_W - 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      rx_sh      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (!active || start) begin
        cnt <= '0;
      end else if (sample) begin
        rx_sh <= rx_next;
        if (cnt == CW'(WORD_W - 1)) begin
          cnt        <= '0;
          rx_data_o  <= rx_next;
          rx_valid_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R8: the received-word strobe lasts a single cycle
  assert_valid_single_R8 : assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  // R9: leaving the frame clears the bit position and suppresses the strobe
  assert_abort_clears_R9 : assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt == '0 && !rx_valid_o));

endmodule

// File: rtl/spi_slv_tx.sv
module spi_slv_tx
  import spi_slv_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter bit CPHA   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  spi_evt_t          evt,
  input  logic              req_open,
  input  logic              word_done,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_wr_i,
  output logic              tx_req_o,
  output logic              miso_o,
  output logic              miso_oe_o
);

  logic [WORD_W-1:0] sh, hold;
  logic full, first, pend, skip;
  logic edge_any, load_now;

  assign edge_any = evt.sample | evt.shift;
  assign load_now = CPHA ? word_done : (pend & evt.shift);
  assign miso_o   = miso_oe_o & sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; hold <= '0;
      full <= 1'b0; first <= 1'b0; pend <= 1'b0; skip <= 1'b0;
      tx_req_o <= 1'b0; miso_oe_o <= 1'b0;
    end else if (!evt.active) begin
      sh <= '0;
      full <= 1'b0; first <= 1'b0; pend <= 1'b0; skip <= 1'b0;
      tx_req_o <= 1'b0; miso_oe_o <= 1'b0;
    end else if (evt.start) begin
      sh        <= '0;
      full      <= 1'b0;
      first     <= 1'b1;
      pend      <= 1'b0;
      skip      <= CPHA;
      tx_req_o  <= 1'b1;
      miso_oe_o <= 1'b1;
    end else begin
      // first word: write goes straight to the shifter until the first edge
      if (first) begin
        if (edge_any) begin
          first    <= 1'b0;
          tx_req_o <= 1'b0;
        end else if (tx_wr_i) begin
          sh <= tx_data_i;
        end
      end else begin
        if (req_open) tx_req_o <= 1'b1;
        if (tx_req_o && tx_wr_i) begin
          hold <= tx_data_i;
          full <= 1'b1;
        end
      end
      if (!CPHA && word_done) pend <= 1'b1;
      if (load_now) begin
        sh       <= full ? hold : '0;
        full     <= 1'b0;
        pend     <= 1'b0;
        skip     <= CPHA;
        tx_req_o <= 1'b0;
      end else if (evt.shift) begin
        if (skip) skip <= 1'b0;
        else      sh   <= {sh[WORD_W-2:0], 1'b0};
      end
    end
  end

  // R3: a new frame opens the request with a zeroed word
  assert_open_first_R3 : assert property (@(posedge clk) disable iff (rst)
    evt.start |=> (tx_req_o && first && sh == '0));

  // R5: a request is only raised while the slave drives MISO
  assert_req_while_driving_R5 : assert property (@(posedge clk) disable iff (rst)
    tx_req_o |-> miso_oe_o);

  // R6: a load with nothing written sends zeros
  assert_zero_fill_R6 : assert property (@(posedge clk) disable iff (rst)
    (load_now && !full && evt.active && !evt.start) |=> sh == '0);

  // R9: released select drops both request and drive
  assert_abort_idle_R9 : assert property (@(posedge clk) disable iff (rst)
    !evt.active |=> (!tx_req_o && !miso_oe_o));

endmodule

// File: rtl/spi_word_slave.sv
module spi_word_slave
  import spi_slv_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter bit CPOL        = 1'b0,
  parameter bit CPHA        = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_wr_i,
  output logic              tx_req_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o
);

  localparam logic [2:0] SYNC_RST = {1'b0, 1'b1, CPOL};

  logic [2:0] sync_q;
  logic       sck_s, ss_n_s, mosi_s;
  spi_evt_t   evt;
  logic       req_open, word_done;

  spi_slv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({mosi_i, ss_n_i, sck_i}),
    .q_o (sync_q)
  );
  assign {mosi_s, ss_n_s, sck_s} = sync_q;

  spi_slv_events #(.CPOL(CPOL), .CPHA(CPHA)) u_evt (
    .clk    (clk),
    .rst    (rst),
    .sck_s  (sck_s),
    .ss_n_s (ss_n_s),
    .evt_o  (evt)
  );

  spi_slv_rx #(.WORD_W(WORD_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .active      (evt.active),
    .start       (evt.start),
    .sample      (evt.sample),
    .mosi_s      (mosi_s),
    .rx_data_o   (rx_data_o),
    .rx_valid_o  (rx_valid_o),
    .req_open_o  (req_open),
    .word_done_o (word_done)
  );

  spi_slv_tx #(.WORD_W(WORD_W), .CPHA(CPHA)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .req_open  (req_open),
    .word_done (word_done),
    .tx_data_i (tx_data_i),
    .tx_wr_i   (tx_wr_i),
    .tx_req_o  (tx_req_o),
    .miso_o    (miso_o),
    .miso_oe_o (miso_oe_o)
  );

  // R11: an undriven MISO reads as zero
  assert_idle_low_R11 : assert property (@(posedge clk) disable iff (rst)
    !miso_oe_o |-> !miso_o);

  // R9: requests exist only inside a selected frame
  assert_req_in_frame_R9 : assert property (@(posedge clk) disable iff (rst)
    tx_req_o |-> $past(!ss_n_s));

endmodule

// File: tb/spi_word_slave_test.sv
`timescale 1ns/1ps
module spi_word_slave_test;

  localparam int W  = 8;
  localparam int H  = 5;   // SCK half period in clk cycles
  localparam int NV = 8;

  typedef struct packed {
    logic [1:0] mode;   // {CPOL, CPHA}
    logic [2:0] miss;   // bit k set: no write for word k
    logic [7:0] s0, s1, s2;
    logic [7:0] m0, m1, m2;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'b000, 8'hA5, 8'h3C, 8'hF0, 8'h96, 8'h0F, 8'h81},
    '{2'd0, 3'b010, 8'h12, 8'h34, 8'h56, 8'hFE, 8'h01, 8'h7E},
    '{2'd1, 3'b000, 8'hC3, 8'h5A, 8'h81, 8'h33, 8'hCC, 8'h55},
    '{2'd1, 3'b101, 8'hFF, 8'h69, 8'hEE, 8'h80, 8'h01, 8'hAA},
    '{2'd2, 3'b000, 8'h0F, 8'hF0, 8'h99, 8'h42, 8'h24, 8'hBD},
    '{2'd2, 3'b001, 8'h77, 8'h88, 8'h1E, 8'hE1, 8'h3B, 8'hC4},
    '{2'd3, 3'b000, 8'h6D, 8'hB2, 8'h01, 8'h80, 8'h7F, 8'hDB},
    '{2'd3, 3'b110, 8'h48, 8'hFA, 8'hCE, 8'h0A, 8'h50, 8'hA0}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic sck_base = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic tx_wr = 1'b0;
  logic [1:0] mode_sel = 2'd0;

  logic [3:0] sck_v, ss_v, miso_v, oe_v, req_v, val_v;
  logic [W-1:0] rxd_a [4];

  for (genvar m = 0; m < 4; m++) begin : g_mode
    assign sck_v[m] = sck_base ^ (m >= 2);
    assign ss_v[m]  = (mode_sel == 2'(m)) ? ss_n : 1'b1;
    spi_word_slave #(.WORD_W(W), .CPOL(m / 2), .CPHA(m % 2)) uut (
      .clk       (clk),
      .rst       (rst),
      .sck_i     (sck_v[m]),
      .ss_n_i    (ss_v[m]),
      .mosi_i    (mosi),
      .miso_o    (miso_v[m]),
      .miso_oe_o (oe_v[m]),
      .tx_data_i (tx_data),
      .tx_wr_i   (tx_wr),
      .tx_req_o  (req_v[m]),
      .rx_data_o (rxd_a[m]),
      .rx_valid_o(val_v[m])
    );
  end

  int nchk = 0, nfail = 0;
  logic [W-1:0] m_tx [3], m_rx [3], s_tx [3];
  logic [2:0] miss = '0;
  logic hold_wr = 1'b0;
  logic [W-1:0] hold_val = '0;
  int req_idx = 0, nw_cur = 0, rx_n = 0;
  logic [W-1:0] rx_log [8];
  logic req_seen = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Parallel-side responder: answers each request once per window.
  initial begin
    forever begin
      @(negedge clk);
      if (hold_wr) begin
        tx_wr   = 1'b1;
        tx_data = hold_val;
      end else begin
        tx_wr = 1'b0;
        if (req_v[mode_sel] && !req_seen) begin
          req_seen = 1'b1;
          if (req_idx < nw_cur && !miss[req_idx]) begin
            tx_wr   = 1'b1;
            tx_data = s_tx[req_idx];
          end
          req_idx++;
        end else if (!req_v[mode_sel]) begin
          req_seen = 1'b0;
        end
      end
    end
  end

  // Received-word monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (val_v[mode_sel]) begin
        if (rx_n < 8) rx_log[rx_n] = rxd_a[mode_sel];
        rx_n++;
      end
    end
  end

  // Behavioural master: nbits bits across consecutive words, then release select.
  task automatic run_xfer(input int nw, input int nbits);
    req_idx = 0;
    nw_cur  = nw;
    rx_n    = 0;
    ss_n    = 1'b0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      int w = k / W;
      int b = W - 1 - (k % W);
      if (!mode_sel[0]) begin
        mosi = m_tx[w][b];
        repeat (H) @(negedge clk);
        sck_base = 1'b1;
        m_rx[w][b] = miso_v[mode_sel];
        repeat (H) @(negedge clk);
        sck_base = 1'b0;
      end else begin
        sck_base = 1'b1;
        mosi = m_tx[w][b];
        repeat (H) @(negedge clk);
        sck_base = 1'b0;
        m_rx[w][b] = miso_v[mode_sel];
        repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk);
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R10 R11: reset state of every mode instance
    chk("R10 R11 miso_oe after reset", {28'd0, oe_v}, 32'd0);
    chk("R10 R11 miso after reset", {28'd0, miso_v}, 32'd0);
    chk("R10 tx_req after reset", {28'd0, req_v}, 32'd0);
    chk("R10 rx_valid after reset", {28'd0, val_v}, 32'd0);
    chk("R10 rx_data after reset", {24'd0, rxd_a[3]}, 32'd0);

    // Table of frames: three back-to-back words in each mode.
    for (int i = 0; i < NV; i++) begin
      mode_sel = VECS[i].mode;
      miss     = VECS[i].miss;
      s_tx[0] = VECS[i].s0; s_tx[1] = VECS[i].s1; s_tx[2] = VECS[i].s2;
      m_tx[0] = VECS[i].m0; m_tx[1] = VECS[i].m1; m_tx[2] = VECS[i].m2;
      run_xfer(3, 3 * W);
      for (int w = 0; w < 3; w++) begin
        chk($sformatf("R1 R2 R3 R4 R5 R6 miso word %0d vec %0d", w, i),
            {24'd0, m_rx[w]}, {24'd0, miss[w] ? 8'h00 : s_tx[w]});
        chk($sformatf("R1 R8 rx word %0d vec %0d", w, i),
            {24'd0, rx_log[w]}, {24'd0, m_tx[w]});
      end
      chk($sformatf("R8 rx strobe count vec %0d", i), rx_n, 32'd3);
      chk($sformatf("R9 idle after frame vec %0d", i),
          {30'd0, oe_v[mode_sel], req_v[mode_sel]}, 32'd0);
    end

    // R9: frame cut after three bits, then a clean frame
    mode_sel = 2'd0;
    miss = 3'b000;
    m_tx[0] = 8'hE7; s_tx[0] = 8'h99;
    run_xfer(1, 3);
    chk("R9 miso_oe after abort", {31'd0, oe_v[0]}, 32'd0);
    chk("R9 tx_req after abort", {31'd0, req_v[0]}, 32'd0);
    chk("R9 R11 miso after abort", {31'd0, miso_v[0]}, 32'd0);
    chk("R9 no strobe for partial word", rx_n, 32'd0);
    m_tx[0] = 8'h3C; s_tx[0] = 8'hC3;
    run_xfer(1, W);
    chk("R9 rx word after abort", {24'd0, rx_log[0]}, 32'h3C);
    chk("R9 miso word after abort", {24'd0, m_rx[0]}, 32'hC3);
    chk("R9 strobe count after abort", rx_n, 32'd1);

    // R7: write strobe held high for a whole frame
    for (int md = 1; md < 4; md += 2) begin
      mode_sel = 2'(md);
      hold_val = 8'h5A;
      hold_wr  = 1'b1;
      m_tx[0] = 8'h11; m_tx[1] = 8'h22; m_tx[2] = 8'h44;
      run_xfer(3, 3 * W);
      hold_wr = 1'b0;
      for (int w = 0; w < 3; w++) begin
        chk($sformatf("R7 held write miso word %0d mode %0d", w, md),
            {24'd0, m_rx[w]}, 32'h5A);
      end
      chk($sformatf("R7 R8 rx last word mode %0d", md), {24'd0, rx_log[2]}, 32'h44);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule